// File: doc/BRIEF.md
# SPI Master Controller with Register Port

This block is a memory-mapped SPI master. A simple synchronous register port (word index, read strobe, write strobe, 32-bit data) reaches six words: mode, timing, control, status, data and a read-only feature word. Software pushes frames through the data word into a transmit FIFO. A shift engine serialises each frame on `mosi` while toggling `sclk`, and collects the same number of bits from `miso` or from its own output when loopback is on. Each collected frame goes into a receive FIFO, which software drains through the same data word.

The serial clock comes from a programmable divider. Clock polarity, sampling phase, bit order and frame length (1 to 32 bits) are all programmable. The control word gates the engine with separate enables for the core, for transmission, for reception and for driving the data output. It also selects one of four chip-select lines and sets that line's level. The status word shows the FIFO levels and a busy flag, so software can tell when the last frame has fully landed.

Word indices on `busAddr`: 0 mode, 1 timing, 2 control, 3 status, 4 data, 5 feature.

Top module: `spim_top`

## Requirements
- R1: After reset, the mode word (index 0), timing word (index 1) and control word (index 2) read 0. The status word (index 3) reads 0x0000_0002, `csOut` is 4'b1110, and `sclk` and `mosiOe` are 0.
- R2: The feature word (index 5) reads 0x040F0F1F. Bits 7:0 hold the largest frame size less one (31). Bits 15:8 hold the receive FIFO depth less one and bits 23:16 the transmit FIFO depth less one. Bit 26 is set to flag SPI capability.
- R3: Timing bits 15:0 hold the divider less one. One `sclk` period lasts 2*max(field+1, 2) clock cycles, so a field of 0 behaves like a divider of 2.
- R4: Timing bits 20:16 hold the frame size less one. Every frame shifts field+1 bits. A received frame appears right-aligned in the data word, with every bit above the frame size at 0.
- R5: Mode bit 1 (CPOL) is the `sclk` level between frames. With mode bit 0 (CPHA) at 0, input is sampled on the first (leading) edge of each bit and output changes on the trailing edge. With CPHA at 1, output changes on the leading edge and input is sampled on the trailing edge.
- R6: Mode bit 2 set sends and receives the least significant bit first. Clear, the most significant bit goes first. The setting applies in both directions.
- R7: Mode bit 3 set feeds the outgoing serial bit stream into the receive path in place of `miso`.
- R8: A frame starts only while control bit 0 (core enable) and control bit 1 (transmit enable) are both 1 and the transmit FIFO holds data. A completed frame enters the receive FIFO only while control bit 2 (receive enable) is 1.
- R9: `mosiOe` is 1 exactly when control bits 0 and 3 (data output enable) are both 1. `mosi` stays 0 whenever `mosiOe` is 0.
- R10: Writing 1 to control bit 4 empties the transmit FIFO, and writing 1 to control bit 5 empties the receive FIFO. Both bits always read back as 0.
- R11: In the status word, bit 0 flags a full receive FIFO and bit 1 flags a transmit FIFO with room. Bits 8:4 give the receive entry count and bits 16:12 the transmit entry count.
- R12: A write to the data word (index 4) pushes a frame, and a read from it pops one. A write while 16 frames wait is dropped. A read from an empty receive FIFO returns 0 and changes no count. A frame finishing while the receive FIFO is full is discarded.
- R13: Status bit 2 (busy) is 1 while the transmit FIFO holds data or a frame is shifting. It falls in the same cycle that the final frame's receive entry is counted.
- R14: Control bits 11:10 choose one of the four `csOut` lines, and control bit 9 gives the level on that line. The three unchosen lines stay at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register word index |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busRead | input | 1 | Read strobe, one cycle per access; a data-word read pops at the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid during the read cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data in |
| csOut | output | 4 | Chip-select lines |

## Verification
The hardest behaviour to reach is the engine running against a real far-end device in every polarity, phase and bit-order combination. The received bits must come from `miso` at exactly the sampling edges, while `mosi` is read at the same edges. The bench contains a slave model that reacts to `sclk` transitions. It presents the next pattern bit after each sampling edge and records `mosi` on that edge, so any shift in sampling or launch timing corrupts both words. Receive-FIFO overflow is also awkward to reach. It is forced by sending seventeen short frames in loopback with no reads in between, and the bench then confirms that the oldest entry survives.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int DIV_W = 16;
  localparam int LEN_W = 5;

  typedef enum logic [2:0] {
    ADDR_MODE    = 3'd0,
    ADDR_TIMING  = 3'd1,
    ADDR_CTRL    = 3'd2,
    ADDR_STATUS  = 3'd3,
    ADDR_DATA    = 3'd4,
    ADDR_FEATURE = 3'd5
  } regAddr_e;

  // configuration seen by the shift engine
  typedef struct packed {
    logic             cpha;
    logic             cpol;
    logic             lsbFirst;
    logic             loopback;
    logic             coreEn;
    logic             txEn;
    logic             rxEn;
    logic             outEn;
    logic [DIV_W-1:0] divM1;
    logic [LEN_W-1:0] lenM1;
  } cfg_t;

  // single-cycle requests from control to datapath
  typedef struct packed {
    logic        txPush;
    logic        rxPop;
    logic        txClear;
    logic        rxClear;
    logic [31:0] wdata;
  } strobe_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [LVL_W-1:0] level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign doPush = push && (level != LVL_W'(DEPTH));
  assign doPop  = pop && (level != '0);
  assign rdata  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clear) mem[wrPtr] <= wdata;
  end

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_BITS   = 32,
  parameter int CS_COUNT   = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int CSI_W     = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          busAddr,
  input  logic                busWrite,
  input  logic                busRead,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output cfg_t                cfg,
  output strobe_t             strobe,
  output logic [CS_COUNT-1:0] csOut,
  input  logic [LVL_W-1:0]    txLevel,
  input  logic [LVL_W-1:0]    rxLevel,
  input  logic [31:0]         rxData,
  input  logic                engineActive
);

  logic [3:0]       modeReg;
  logic [DIV_W-1:0] divReg;
  logic [LEN_W-1:0] lenReg;
  logic [3:0]       enReg;      // outEn, rxEn, txEn, coreEn
  logic             fsLevel;
  logic [CSI_W-1:0] csIndex;

  logic wrMode, wrTiming, wrCtrl;
  logic rxFull, txRoom, busyFlag;

  assign wrMode   = busWrite && (busAddr == ADDR_MODE);
  assign wrTiming = busWrite && (busAddr == ADDR_TIMING);
  assign wrCtrl   = busWrite && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      divReg  <= '0;
      lenReg  <= '0;
      enReg   <= '0;
      fsLevel <= 1'b0;
      csIndex <= '0;
    end else begin
      if (wrMode) modeReg <= busWdata[3:0];
      if (wrTiming) begin
        divReg <= busWdata[15:0];
        lenReg <= busWdata[20:16];
      end
      if (wrCtrl) begin
        enReg   <= busWdata[3:0];
        fsLevel <= busWdata[9];
        csIndex <= busWdata[10 +: CSI_W];
      end
    end
  end

  always_comb begin
    cfg.cpha     = modeReg[0];
    cfg.cpol     = modeReg[1];
    cfg.lsbFirst = modeReg[2];
    cfg.loopback = modeReg[3];
    cfg.coreEn   = enReg[0];
    cfg.txEn     = enReg[1];
    cfg.rxEn     = enReg[2];
    cfg.outEn    = enReg[3];
    cfg.divM1    = divReg;
    cfg.lenM1    = lenReg;
  end

  always_comb begin
    strobe.txPush  = busWrite && (busAddr == ADDR_DATA);
    strobe.rxPop   = busRead && (busAddr == ADDR_DATA);
    strobe.txClear = wrCtrl && busWdata[4];
    strobe.rxClear = wrCtrl && busWdata[5];
    strobe.wdata   = busWdata;
  end

  assign rxFull   = (rxLevel == LVL_W'(FIFO_DEPTH));
  assign txRoom   = (txLevel != LVL_W'(FIFO_DEPTH));
  assign busyFlag = engineActive || (txLevel != '0);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_MODE:    busRdata[3:0] = modeReg;
      ADDR_TIMING:  busRdata = {11'd0, lenReg, divReg};
      ADDR_CTRL: begin
        busRdata[3:0]          = enReg;
        busRdata[9]            = fsLevel;
        busRdata[10 +: CSI_W]  = csIndex;
      end
      ADDR_STATUS: begin
        busRdata[0]     = rxFull;
        busRdata[1]     = txRoom;
        busRdata[2]     = busyFlag;
        busRdata[8:4]   = 5'(rxLevel);
        busRdata[16:12] = 5'(txLevel);
      end
      ADDR_DATA:    busRdata = (rxLevel != '0) ? rxData : 32'd0;
      ADDR_FEATURE: busRdata = {5'd0, 1'b1, 2'd0, 8'(FIFO_DEPTH - 1),
                                8'(FIFO_DEPTH - 1), 8'(MAX_BITS - 1)};
      default:      busRdata = '0;
    endcase
  end

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    assign csOut[i] = (csIndex == CSI_W'(i)) ? fsLevel : 1'b1;
  end

endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_BITS   = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int EDGE_W    = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  strobe_t          strobe,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             mosiOe,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic [31:0]      rxData,
  output logic             engineActive
);

  logic [31:0]         txHead;
  logic                startFrame, rxPush;
  logic [31:0]         rxPushData;

  logic                active, phase, lsbLatched;
  logic [DIV_W-1:0]    halfCnt, halfLimit;
  logic [EDGE_W-1:0]   edgeCnt;
  logic [LEN_W-1:0]    lenLatched;
  logic [MAX_BITS-1:0] txShift, rxShift, rxNext, rxFinal;
  logic                halfTick, lastEdge, sampleEdge, shiftEdge;
  logic                txBit, bitIn;
  logic [5:0]          alignShift;

  spim_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .clear(strobe.txClear), .push(strobe.txPush),
    .pop(startFrame), .wdata(strobe.wdata), .rdata(txHead), .level(txLevel)
  );

  spim_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .clear(strobe.rxClear), .push(rxPush),
    .pop(strobe.rxPop), .wdata(rxPushData), .rdata(rxData), .level(rxLevel)
  );

  assign halfLimit  = (cfg.divM1 == '0) ? DIV_W'(1) : cfg.divM1;
  assign halfTick   = active && (halfCnt == halfLimit);
  assign lastEdge   = (edgeCnt == {lenLatched, 1'b1});
  assign sampleEdge = (edgeCnt[0] == cfg.cpha);
  assign shiftEdge  = cfg.cpha ? (!edgeCnt[0] && (edgeCnt != '0))
                               : (edgeCnt[0] && !lastEdge);
  assign startFrame = !active && cfg.coreEn && cfg.txEn && (txLevel != '0);

  assign txBit = lsbLatched ? txShift[0] : txShift[lenLatched];
  assign bitIn = cfg.loopback ? txBit : miso;

  assign rxNext  = lsbLatched ? {bitIn, rxShift[MAX_BITS-1:1]}
                              : {rxShift[MAX_BITS-2:0], bitIn};
  assign rxFinal = sampleEdge ? rxNext : rxShift;
  assign alignShift = 6'(MAX_BITS - 1) - {1'b0, lenLatched};
  assign rxPushData = 32'(lsbLatched ? (rxFinal >> alignShift) : rxFinal);
  assign rxPush     = halfTick && cfg.coreEn && lastEdge && cfg.rxEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      phase      <= 1'b0;
      halfCnt    <= '0;
      edgeCnt    <= '0;
      txShift    <= '0;
      rxShift    <= '0;
      lenLatched <= '0;
      lsbLatched <= 1'b0;
    end else if (active && !cfg.coreEn) begin
      active <= 1'b0;
      phase  <= 1'b0;
    end else if (startFrame) begin
      active     <= 1'b1;
      phase      <= 1'b0;
      halfCnt    <= '0;
      edgeCnt    <= '0;
      txShift    <= MAX_BITS'(txHead);
      rxShift    <= '0;
      lenLatched <= cfg.lenM1;
      lsbLatched <= cfg.lsbFirst;
    end else if (active) begin
      if (halfTick) begin
        halfCnt <= '0;
        phase   <= ~phase;
        edgeCnt <= edgeCnt + 1'b1;
        if (sampleEdge) rxShift <= rxNext;
        if (shiftEdge)  txShift <= lsbLatched ? (txShift >> 1) : (txShift << 1);
        if (lastEdge)   active <= 1'b0;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  assign sclk         = cfg.cpol ^ phase;
  assign mosiOe       = cfg.coreEn && cfg.outEn;
  assign mosi         = mosiOe && txBit;
  assign engineActive = active;

endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_BITS   = 32,
  parameter int CS_COUNT   = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          busAddr,
  input  logic                busWrite,
  input  logic                busRead,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                sclk,
  output logic                mosi,
  output logic                mosiOe,
  input  logic                miso,
  output logic [CS_COUNT-1:0] csOut
);

  cfg_t             cfgBus;
  strobe_t          strobeBus;
  logic [LVL_W-1:0] txLevel, rxLevel;
  logic [31:0]      rxData;
  logic             engineActive;
  logic             cpolLive;

  assign cpolLive = cfgBus.cpol;

  spim_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .MAX_BITS(MAX_BITS), .CS_COUNT(CS_COUNT)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata),
    .cfg(cfgBus), .strobe(strobeBus), .csOut(csOut),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxData(rxData),
    .engineActive(engineActive)
  );

  spim_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .MAX_BITS(MAX_BITS)) uData (
    .clk(clk), .rstN(rstN), .cfg(cfgBus), .strobe(strobeBus), .miso(miso),
    .sclk(sclk), .mosi(mosi), .mosiOe(mosiOe), .txLevel(txLevel),
    .rxLevel(rxLevel), .rxData(rxData), .engineActive(engineActive)
  );

endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int FIFO_DEPTH = 16,
  parameter int CS_COUNT   = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          busAddr,
  input logic                busRead,
  input logic [31:0]         busRdata,
  input logic                sclk,
  input logic                mosi,
  input logic                mosiOe,
  input logic [CS_COUNT-1:0] csOut,
  input logic                cpolLive,
  input logic                engineActive,
  input logic [LVL_W-1:0]    txLevel,
  input logic [LVL_W-1:0]    rxLevel
);

  p_mosi_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !mosiOe |-> !mosi);

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    !engineActive |-> (sclk == cpolLive));

  p_cs_single_r14: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csOut) <= 1);

  p_level_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LVL_W'(FIFO_DEPTH)) && (rxLevel <= LVL_W'(FIFO_DEPTH)));

  p_busy_shown_r13: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 3'd3 && engineActive) |-> busRdata[2]);

  p_clear_reads_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 3'd2) |-> (busRdata[5:4] == 2'b00));

  p_empty_read_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 3'd4 && rxLevel == '0) |-> (busRdata == 32'd0));

  p_empty_pop_keeps_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 3'd4 && rxLevel == '0 && !engineActive) |=> (rxLevel == '0));

endmodule

bind spim_top spim_checker #(.FIFO_DEPTH(FIFO_DEPTH), .CS_COUNT(CS_COUNT)) uChecker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
  .busRdata(busRdata), .sclk(sclk), .mosi(mosi), .mosiOe(mosiOe),
  .csOut(csOut), .cpolLive(cpolLive), .engineActive(engineActive),
  .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/spim_top_test.sv
`timescale 1ns/1ps
module spim_top_test;

  localparam logic [2:0] A_MODE = 3'd0, A_TIM = 3'd1, A_CTRL = 3'd2,
                         A_STAT = 3'd3, A_DATA = 3'd4, A_FEAT = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrite = 1'b0, busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sclk, mosi, mosiOe, miso;
  logic [3:0]  csOut;

  always #2.5 clk = ~clk;

  spim_top uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata),
    .sclk(sclk), .mosi(mosi), .mosiOe(mosiOe), .miso(miso), .csOut(csOut)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R13 watchdog actual=%0d cycles expected=completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // far-end slave model
  logic        armed = 1'b0, sCpol = 1'b0, sCpha = 1'b0, sLsb = 1'b0;
  int          sLen = 8, sK = 0;
  logic [31:0] sPattern = '0, sCaptured = '0;

  always_comb begin
    if (armed && sK < sLen) miso = sPattern[sLsb ? sK : sLen - 1 - sK];
    else miso = 1'b0;
  end

  always @(sclk) begin
    if (armed && sclk == (sCpha ? sCpol : ~sCpol) && sK < sLen) begin
      sCaptured[sLsb ? sK : sLen - 1 - sK] = mosi;
      sK = sK + 1;
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic waitIdle(output logic [31:0] st);
    st = 32'h4;
    for (int i = 0; i < 4000 && st[2]; i++) regRead(A_STAT, st);
  endtask

  function automatic logic [31:0] maskFor(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction

  function automatic logic [31:0] ctrlWord(input logic core, tx, rx, oe);
    return {28'd0, oe, rx, tx, core};
  endfunction

  logic [31:0] rd, st;
  logic [31:0] frames [3];
  realtime     t0, t1;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(A_MODE, rd); check("R1 mode", rd, 0);
    regRead(A_TIM, rd);  check("R1 timing", rd, 0);
    regRead(A_CTRL, rd); check("R1 ctrl", rd, 0);
    regRead(A_STAT, rd); check("R1 status", rd, 32'h2);
    check("R1 cs", {28'd0, csOut}, 32'hE);
    check("R1 sclk/oe", {30'd0, sclk, mosiOe}, 0);

    // R2 feature word
    regRead(A_FEAT, rd); check("R2 feature", rd, 32'h040F_0F1F);

    // R14 chip selects
    regWrite(A_CTRL, (32'd2 << 10));
    check("R14 idx2 low", {28'd0, csOut}, 32'hB);
    regWrite(A_CTRL, (32'd2 << 10) | (32'd1 << 9));
    check("R14 idx2 high", {28'd0, csOut}, 32'hF);
    regWrite(A_CTRL, (32'd3 << 10));
    check("R14 idx3 low", {28'd0, csOut}, 32'h7);

    // R12 / R11 fill transmit FIFO with engine off
    regWrite(A_CTRL, 0);
    for (int i = 0; i < 17; i++) regWrite(A_DATA, i);
    regRead(A_STAT, rd);
    check("R11 R12 tx count full", {27'd0, rd[16:12]}, 16);
    check("R11 tx room flag", {31'd0, rd[1]}, 0);
    check("R13 busy with queued data", {31'd0, rd[2]}, 1);
    regRead(A_DATA, rd); check("R12 empty read", rd, 0);
    regRead(A_STAT, rd); check("R12 rx count after empty read", {27'd0, rd[8:4]}, 0);

    // R10 clear transmit
    regWrite(A_CTRL, 32'h10);
    regRead(A_STAT, rd); check("R10 tx cleared", {27'd0, rd[16:12]}, 0);
    regRead(A_CTRL, rd); check("R10 clear bits read 0", {30'd0, rd[5:4]}, 0);

    // R3 divider
    regWrite(A_MODE, 0);
    regWrite(A_TIM, (32'd31 << 16) | 32'd0);
    regWrite(A_CTRL, ctrlWord(1, 1, 0, 1));
    regWrite(A_DATA, 32'h1234_5678);
    @(posedge sclk); t0 = $realtime; @(posedge sclk); t1 = $realtime;
    check("R3 period div field 0", int'((t1 - t0) / 5.0), 4);
    waitIdle(st);
    regWrite(A_TIM, (32'd31 << 16) | 32'd3);
    regWrite(A_DATA, 32'h1);
    @(posedge sclk); t0 = $realtime; @(posedge sclk); t1 = $realtime;
    check("R3 period div field 3", int'((t1 - t0) / 5.0), 8);
    waitIdle(st);

    // R8 enables
    regWrite(A_CTRL, ctrlWord(1, 0, 1, 1));
    regWrite(A_DATA, 32'h55);
    repeat (40) @(negedge clk);
    regRead(A_STAT, rd);
    check("R8 tx disabled holds frame", {27'd0, rd[16:12]}, 1);
    check("R5 idle sclk", {31'd0, sclk}, 0);
    regWrite(A_CTRL, ctrlWord(1, 1, 0, 1));
    waitIdle(st);
    check("R8 rx disabled drops frame", {27'd0, st[8:4]}, 0);
    check("R8 tx drained", {27'd0, st[16:12]}, 0);
    regWrite(A_CTRL, ctrlWord(0, 1, 1, 1));
    regWrite(A_DATA, 32'h66);
    repeat (40) @(negedge clk);
    regRead(A_STAT, rd);
    check("R8 core off holds frame", {27'd0, rd[16:12]}, 1);
    check("R9 oe off when core off", {31'd0, mosiOe}, 0);
    regWrite(A_CTRL, 32'h10);

    // R4 R6 R7 loopback, random modes, lengths and data
    for (int it = 0; it < 40; it++) begin
      logic cpol, cpha, lsb;
      int len, div, nf;
      cpol = 1'($urandom); cpha = 1'($urandom); lsb = 1'($urandom);
      len = (it == 0) ? 1 : (it == 1) ? 32 : int'($urandom % 32) + 1;
      div = int'($urandom % 3);
      nf  = int'($urandom % 3) + 1;
      regWrite(A_MODE, {28'd0, 1'b1, lsb, cpol, cpha});
      regWrite(A_TIM, (32'(len - 1) << 16) | 32'(div));
      regWrite(A_CTRL, ctrlWord(1, 1, 1, 1));
      for (int f = 0; f < nf; f++) begin
        frames[f] = $urandom;
        regWrite(A_DATA, frames[f]);
      end
      waitIdle(st);
      check("R13 R4 rx count at idle", {27'd0, st[8:4]}, 32'(nf));
      check("R5 idle level", {31'd0, sclk}, {31'd0, cpol});
      for (int f = 0; f < nf; f++) begin
        regRead(A_DATA, rd);
        check("R4 R6 R7 loopback data", rd, frames[f] & maskFor(len));
      end
    end

    // R5 R6 against slave model on miso
    for (int it = 0; it < 16; it++) begin
      logic [31:0] txv;
      int len;
      sCpol = 1'(it); sCpha = 1'(it >> 1); sLsb = 1'(it >> 2);
      len = (it < 8) ? 8 : int'($urandom % 32) + 1;
      sLen = len;
      txv = $urandom; sPattern = $urandom & maskFor(len);
      regWrite(A_MODE, {28'd0, 1'b0, sLsb, sCpol, sCpha});
      regWrite(A_TIM, (32'(len - 1) << 16) | 32'd1);
      regWrite(A_CTRL, ctrlWord(1, 1, 1, 1));
      sK = 0; sCaptured = '0; armed = 1'b1;
      regWrite(A_DATA, txv);
      waitIdle(st);
      armed = 1'b0;
      regRead(A_DATA, rd);
      check("R5 R6 miso frame", rd, sPattern);
      check("R5 R6 mosi frame", sCaptured, txv & maskFor(len));
    end

    // R9 output disabled: mosi stays quiet
    sCpol = 0; sCpha = 0; sLsb = 0; sLen = 8; sPattern = 32'hA5;
    regWrite(A_MODE, 0);
    regWrite(A_TIM, (32'd7 << 16));
    regWrite(A_CTRL, ctrlWord(1, 1, 1, 0));
    check("R9 oe low", {31'd0, mosiOe}, 0);
    sK = 0; sCaptured = '0; armed = 1'b1;
    regWrite(A_DATA, 32'hFF);
    waitIdle(st);
    armed = 1'b0;
    check("R9 mosi quiet", sCaptured, 0);
    regRead(A_DATA, rd); check("R9 rx still works", rd, 32'hA5);
    regWrite(A_CTRL, ctrlWord(1, 1, 1, 1));
    check("R9 oe high", {31'd0, mosiOe}, 1);

    // R12 receive overflow and R10 receive clear
    regWrite(A_MODE, 32'h8);
    regWrite(A_TIM, (32'd3 << 16));
    for (int i = 0; i < 16; i++) regWrite(A_DATA, 32'(i + 1));
    waitIdle(st);
    check("R11 rx full flag", {31'd0, st[0]}, 1);
    regWrite(A_DATA, 32'hF);
    waitIdle(st);
    check("R12 rx count capped", {27'd0, st[8:4]}, 16);
    regRead(A_DATA, rd); check("R12 oldest kept", rd, 1);
    regWrite(A_CTRL, ctrlWord(1, 1, 1, 1) | 32'h20);
    regRead(A_STAT, rd); check("R10 rx cleared", {27'd0, rd[8:4]}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule